// File: doc/BRIEF.md
# DTMF Steering Validator and Receive Register

This block takes the place of an analog RC timing network that decides when a detected dual-tone pair counts as a digit. A tone detector upstream supplies an early-steering level, which is high while two valid tones are present, and the 4-bit code of the tone pair. The block counts clock cycles to decide when the signal has lasted long enough to register a digit. It then counts again to decide when the signal has been absent long enough to end that digit. The two thresholds come from configuration inputs.

When a digit registers, the block copies the code into a receive data register and raises a guard output. A fixed number of cycles later it raises a delayed steering flag, so that the register contents have already settled when the flag appears. Software reads the flag through a status word. It can also enable an active-low interrupt, which is cleared by reading the data register. The validation works in both directions: a tone that is too short never registers, and a dropout that is too short never ends a digit.

Top module: `dtmf_steering`

## Requirements
- R1: A digit registers on the rising edge at which `est_i` has been sampled high on `acq_cycles_i` consecutive rising edges. A value of 0 acts as 1. Any low sample before that point restarts the count.
- R2: On the registering edge, `code_i` is loaded into the receive data register and `guard_o` rises.
- R3: After registration, `guard_o` stays high for as long as `est_i` stays high. It falls on the same edge as the flag at release.
- R4: `flag_o` rises exactly `SETTLE_CYC` (default 4) rising edges after the edge on which `guard_o` rose. `flag_o` is never high while `guard_o` is low.
- R5: The receive data register changes only on a registering edge. Changes on `code_i` at any other time have no effect on it.
- R6: With `rd_addr_i`=0, `rd_data_o` returns the receive data register. With `rd_addr_i`=1, it returns a status word whose bit 0 is `flag_o`, whose bit 1 is `guard_o`, and whose bits 3:2 are zero.
- R7: `irq_n_o` is low only while `irq_en_i`=1, `flag_o`=1 and an interrupt is pending. A pending interrupt is set when the flag rises. It is cleared by a cycle with `rd_en_i`=1 and `rd_addr_i`=0. `irq_n_o` stays high whenever `irq_en_i`=0.
- R8: While the flag is high, the digit ends on the edge at which `est_i` has been sampled low on `rel_cycles_i` consecutive edges (0 acts as 1). Shorter dropouts leave both `flag_o` and `guard_o` high. Release counting begins only once the flag is high.
- R9: After reset, `guard_o`, `flag_o` and the data register are 0, and `irq_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| est_i | input | 1 | Early-steering level from the tone detector |
| code_i | input | 4 | Code of the detected tone pair |
| acq_cycles_i | input | CNT_W | Acquisition time in cycles |
| rel_cycles_i | input | CNT_W | Release time in cycles |
| irq_en_i | input | 1 | Interrupt mode enable |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 1 | Read select: 0 data, 1 status |
| rd_data_o | output | 4 | Read data |
| guard_o | output | 1 | Guard-time output |
| flag_o | output | 1 | Delayed steering flag |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The acquisition side is swept over several acquisition settings, including the zero setting. Each setting is driven with tone bursts from one cycle up to a few cycles longer than the threshold. This places the accept/reject boundary exactly and confirms that rejected bursts leave the data register unchanged. One long tone is sampled on the cycles just before and just after the settle delay to pin down when the flag rises. During that same tone the code input is changed, the status word is read, and the interrupt is gated and then cleared. The release side is swept with dropout lengths below, at and above the release threshold. This separates ignored dropouts from real pauses, and a tone resumed after a short dropout must keep the digit held.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HELD   = 2'd2
    } steer_st_e;

    localparam logic RD_SEL_DATA   = 1'b0;
    localparam logic RD_SEL_STATUS = 1'b1;

    localparam int STAT_FLAG_BIT  = 0;
    localparam int STAT_GUARD_BIT = 1;

    // A programmed length of zero behaves as one cycle
    function automatic logic [31:0] eff_len(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/dtmf_steer_qual.sv
module dtmf_steer_qual
    import dtmf_steer_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             est_i,
    input  logic [CNT_W-1:0] acq_i,
    input  logic [CNT_W-1:0] rel_i,
    output logic             load_o,
    output logic             rise_o,
    output logic             guard_o,
    output logic             flag_o
);

    localparam logic [31:0] SETTLE_LAST = 32'(SETTLE_CYC - 1);

    steer_st_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      cnt_inc;
    logic [31:0]      acq_len;
    logic [31:0]      rel_len;
    logic             acq_done;
    logic             rel_done;
    logic             settle_done;

    always_comb begin
        cnt_inc     = 32'(cnt_q) + 32'd1;
        acq_len     = eff_len(32'(acq_i));
        rel_len     = eff_len(32'(rel_i));
        acq_done    = est_i && (cnt_inc >= acq_len);
        rel_done    = !est_i && (cnt_inc >= rel_len);
        settle_done = (32'(cnt_q) >= SETTLE_LAST);
        load_o      = (st_q == ST_IDLE) && acq_done;
        rise_o      = (st_q == ST_SETTLE) && settle_done;
        guard_o     = (st_q != ST_IDLE);
        flag_o      = (st_q == ST_HELD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (!est_i) begin
                        cnt_q <= '0;
                    end else if (acq_done) begin
                        st_q  <= ST_SETTLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (settle_done) begin
                        st_q  <= ST_HELD;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_HELD: begin
                    if (est_i) begin
                        cnt_q <= '0;
                    end else if (rel_done) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= ST_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    AST_GUARD_NEEDS_TONE: assert property (@(posedge clk) disable iff (rst)
        $rose(guard_o) |-> $past(est_i));                    // R1
    AST_GUARD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (guard_o && est_i) |=> guard_o);                     // R3
    AST_FLAG_INSIDE_GUARD: assert property (@(posedge clk) disable iff (rst)
        flag_o |-> guard_o);                                 // R4
    AST_FLAG_AFTER_GUARD: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(guard_o));                   // R4
    AST_RELEASE_ON_SILENCE: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_o) |-> (!$past(est_i) && !guard_o));      // R8

endmodule

// File: rtl/dtmf_rx_regs.sv
module dtmf_rx_regs
    import dtmf_steer_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              rise_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              guard_i,
    input  logic              flag_i,
    input  logic              irq_en_i,
    input  logic              rd_en_i,
    input  logic              rd_addr_i,
    output logic [CODE_W-1:0] rd_data_o,
    output logic              irq_n_o
);

    logic [CODE_W-1:0] data_q;
    logic              pend_q;
    logic [CODE_W-1:0] status_w;
    logic              data_read;

    always_comb begin
        data_read                = rd_en_i && (rd_addr_i == RD_SEL_DATA);
        status_w                 = '0;
        status_w[STAT_FLAG_BIT]  = flag_i;
        status_w[STAT_GUARD_BIT] = guard_i;
        rd_data_o                = (rd_addr_i == RD_SEL_STATUS) ? status_w : data_q;
        irq_n_o                  = !(irq_en_i && flag_i && pend_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (load_i) begin
                data_q <= code_i;
            end
            if (rise_i) begin
                pend_q <= 1'b1;
            end else if (data_read) begin
                pend_q <= 1'b0;
            end
        end
    end

    AST_DATA_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(data_q));                        // R5
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !irq_n_o |-> (flag_i && irq_en_i));                  // R7
    AST_IRQ_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (rst)
        (data_read && !rise_i) |=> irq_n_o);                 // R7

endmodule

// File: rtl/dtmf_steering.sv
module dtmf_steering
    import dtmf_steer_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             est_i,
    input  logic [3:0]       code_i,
    input  logic [CNT_W-1:0] acq_cycles_i,
    input  logic [CNT_W-1:0] rel_cycles_i,
    input  logic             irq_en_i,
    input  logic             rd_en_i,
    input  logic             rd_addr_i,
    output logic [3:0]       rd_data_o,
    output logic             guard_o,
    output logic             flag_o,
    output logic             irq_n_o
);

    localparam int CODE_W = 4;

    logic load_w;
    logic rise_w;
    logic guard_w;
    logic flag_w;

    dtmf_steer_qual #(
        .CNT_W      (CNT_W),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_qual (
        .clk     (clk),
        .rst     (rst),
        .est_i   (est_i),
        .acq_i   (acq_cycles_i),
        .rel_i   (rel_cycles_i),
        .load_o  (load_w),
        .rise_o  (rise_w),
        .guard_o (guard_w),
        .flag_o  (flag_w)
    );

    dtmf_rx_regs #(
        .CODE_W (CODE_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_w),
        .rise_i    (rise_w),
        .code_i    (code_i),
        .guard_i   (guard_w),
        .flag_i    (flag_w),
        .irq_en_i  (irq_en_i),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .irq_n_o   (irq_n_o)
    );

    assign guard_o = guard_w;
    assign flag_o  = flag_w;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!guard_o && !flag_o && irq_n_o));           // R9

endmodule

// File: tb/dtmf_steering_bench.sv
`timescale 1ns/1ps
module dtmf_steering_bench;

    localparam int CNT_W  = 8;
    localparam int SETTLE = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             est = 1'b0;
    logic [3:0]       code = 4'd0;
    logic [CNT_W-1:0] acq = 8'd1;
    logic [CNT_W-1:0] rel = 8'd1;
    logic             irq_en = 1'b0;
    logic             rd_en = 1'b0;
    logic             rd_addr = 1'b0;
    logic [3:0]       rd_data;
    logic             guard;
    logic             flag;
    logic             irq_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    dtmf_steering #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE)) u_dtmf_steering (
        .clk(clk), .rst(rst), .est_i(est), .code_i(code),
        .acq_cycles_i(acq), .rel_cycles_i(rel), .irq_en_i(irq_en),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .guard_o(guard), .flag_o(flag), .irq_n_o(irq_n)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic read_data(output logic [3:0] v);
        rd_addr = 1'b0;
        #0.1;
        v = rd_data;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] prev;
        logic [3:0] v;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R9 reset state
        check("R9 guard", guard, 0);
        check("R9 flag", flag, 0);
        check("R9 irq_n", irq_n, 1);
        read_data(v);
        check("R9 data", v, 0);
        prev = 4'd0;

        // R1/R2/R5 acquisition sweep
        rel = 8'd1;
        for (int a = 0; a <= 4; a++) begin
            for (int l = 1; l <= 6; l++) begin
                int   a_eff;
                logic reg_ok;
                a_eff  = (a == 0) ? 1 : a;
                reg_ok = (l >= a_eff);
                acq  = CNT_W'(a);
                code = 4'((a * 7 + l * 3 + 1) % 16);
                est  = 1'b1;
                tick(l);
                check("R1 guard vs burst length", guard, reg_ok);
                read_data(v);
                if (reg_ok) begin
                    check("R2 code latched", v, code);
                    prev = code;
                end else begin
                    check("R5 data kept on rejected burst", v, prev);
                end
                est = 1'b0;
                tick(SETTLE + 4);
                check("R8 idle after pause guard", guard, 0);
                check("R8 idle after pause flag", flag, 0);
            end
        end

        // R1 restart on early drop: 2 high, 1 low, 2 high with acq=3
        acq = 8'd3;
        est = 1'b1; tick(2);
        est = 1'b0; tick(1);
        est = 1'b1; tick(2);
        check("R1 restart after drop", guard, 0);
        tick(1);
        check("R1 register after full run", guard, 1);
        est = 1'b0; tick(SETTLE + 4);

        // R4 flag timing, R6 status, R7 irq, R5 code change ignored
        acq = 8'd2; rel = 8'd2; irq_en = 1'b0;
        code = 4'hB;
        est = 1'b1;
        tick(1);
        check("R1 not yet", guard, 0);
        tick(1);
        check("R2 guard at registration", guard, 1);
        check("R4 flag low at registration", flag, 0);
        tick(SETTLE - 1);
        check("R4 flag low before settle", flag, 0);
        tick(1);
        check("R4 flag after settle", flag, 1);
        check("R7 irq off when disabled", irq_n, 1);
        irq_en = 1'b1;
        #0.1;
        check("R7 irq asserted", irq_n, 0);
        rd_addr = 1'b1;
        #0.1;
        check("R6 status word", rd_data, 4'b0011);
        code = 4'h2;
        tick(3);
        read_data(v);
        check("R5 data ignores code change", v, 4'hB);
        check("R3 guard held with tone", guard, 1);
        check("R7 irq held before read", irq_n, 0);
        rd_en = 1'b1; rd_addr = 1'b0;
        tick(1);
        rd_en = 1'b0;
        check("R7 irq cleared by read", irq_n, 1);
        check("R7 flag stays after read", flag, 1);
        est = 1'b0;
        tick(2);
        check("R3 guard falls at release", guard, 0);
        rd_addr = 1'b1;
        #0.1;
        check("R6 status idle", rd_data, 4'b0000);
        rd_addr = 1'b0;
        tick(2);

        // R8 release sweep with rel=3
        acq = 8'd1; rel = 8'd3; irq_en = 1'b1;
        for (int d = 1; d <= 5; d++) begin
            logic keep;
            keep = (d < 3);
            code = 4'(d);
            est  = 1'b1;
            tick(1 + SETTLE + 1);
            check("R4 flag up", flag, 1);
            check("R7 irq on new digit", irq_n, 0);
            est = 1'b0;
            tick(d);
            check("R8 flag vs dropout", flag, keep);
            check("R8 guard vs dropout", guard, keep);
            if (keep) begin
                est = 1'b1;
                tick(2);
                check("R8 held after resumed tone", flag, 1);
                est = 1'b0;
            end
            tick(6);
            check("R8 released", flag, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule